// File: doc/BRIEF.md
# Paged Virtual Register Window Decoder

This block is a memory-mapped target that gives each device function its own set of 32-bit virtual registers. The registers are spread over two 4 KiB pages. The offset is split the same way as an enhanced (memory-mapped) configuration address, with one extra bit that selects the page. Each request carries a 29-bit offset, a byte count, a write flag and a write word. One cycle after the request, the block returns a response flag, a read word and an error flag.

The offset is decoded as follows:

| Field | Offset bits |
|-------|-------------|
| bus | 28:21 |
| device | 20:16 |
| function | 15:13 |
| page | 12 |
| register index | 11:2 |

Only naturally aligned 4-byte accesses are accepted. Any other access raises the error flag, reads zero and changes no storage. Backing storage exists only for a parameterised set of functions: bus 0, devices 1 to `DEV_COUNT`, functions 0 to `FUNC_COUNT-1`, and the first `REGS_PER_PAGE` indices of each page. Every other address, including the host-bridge function at bus 0 / device 0 / function 0, reads zero and ignores writes without raising an error. Data travels as a little-endian 32-bit word: bits 7:0 of the data belong to the lowest-addressed byte.

Top module: `pvw_window`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_err` are 0, and every implemented register reads 0.
- R2: Each request cycle produces exactly one response cycle: `rsp_valid` is high in the cycle after `req_valid` and low after an idle cycle. The response to a write always carries `rsp_rdata` = 0.
- R3: A write to an implemented register followed by a read of the same offset returns the written word. Page bit 12 selects between two separate stores for the same register index.
- R4: Each implemented device/function pair has its own storage. A write to one pair leaves the same register of every other pair unchanged.
- R5: An access whose offset bits 1:0 are not zero is rejected. `rsp_err` is 1 for that response only, the read word is 0 and no storage changes.
- R6: An access whose byte count `req_len` is not 4 is rejected in the same way as in R5.
- R7: A well-formed access to bus 0 / device 0 / function 0 (either page, any index) reads 0, changes no storage and does not raise `rsp_err`.
- R8: A well-formed access to an absent function reads 0, does not raise `rsp_err` and does not alias onto implemented storage. An absent function is one with a bus other than 0, a device above `DEV_COUNT`, or a function at or above `FUNC_COUNT`.
- R9: A register index at or above `REGS_PER_PAGE` reads 0 and is dropped on write. It does not wrap onto a lower index.
- R10: Back-to-back requests each get their own response. An error on one request does not spill onto the following request's response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | Window offset (bus, device, function, page, index, byte lane) |
| req_len | input | 3 | Access length in bytes; only 4 is accepted |
| req_wdata | input | 32 | Little-endian write word |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read word; 0 for writes, rejected accesses and unimplemented targets |
| rsp_err | output | 1 | One-cycle flag for a rejected access |

## Verification
The bench uses the default parameters: `DEV_COUNT`=2, `FUNC_COUNT`=2 and `REGS_PER_PAGE`=8. This gives four implemented functions of 16 words each. Because device 3, function 2 and index 8 are then just outside the implemented set, the bench can show that out-of-set offsets do not wrap onto real storage. For example, index 8 would alias index 0, and index 11 would alias index 3. The same small storage also lets the bench confirm, after each rejected or ignored write, that a known word in another function and another page is unchanged.

// File: rtl/pvw_pkg.sv
package pvw_pkg;

  localparam int OFF_W = 29;

  // Field split of a window offset, most significant field first.
  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic       page;
    logic [9:0] idx;
    logic [1:0] lane;
  } pvw_fields_t;

  function automatic pvw_fields_t pvw_split(logic [OFF_W-1:0] off);
    return pvw_fields_t'(off);
  endfunction

  // A well-formed access is a whole dword on a dword boundary.
  function automatic logic pvw_shape_ok(logic [2:0] len, logic [1:0] lane);
    return (len == 3'd4) && (lane == 2'd0);
  endfunction

  // Linear word position inside the backing store for an implemented slot.
  function automatic int pvw_word_index(pvw_fields_t f, int funcs, int rpp);
    return ((int'(f.dev) - 1) * funcs + int'(f.fn)) * 2 * rpp
           + int'(f.page) * rpp + int'(f.idx);
  endfunction

endpackage

// File: rtl/pvw_decode.sv
module pvw_decode
  import pvw_pkg::*;
#(
  parameter int DEV_COUNT     = 2,
  parameter int FUNC_COUNT    = 2,
  parameter int REGS_PER_PAGE = 8,
  localparam int DEPTH = DEV_COUNT * FUNC_COUNT * 2 * REGS_PER_PAGE,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [OFF_W-1:0] addr,
  input  logic [2:0]       len,
  output logic             shape_bad,
  output logic             root_hit,
  output logic             slot_hit,
  output logic [IDX_W-1:0] word_idx
);

  pvw_fields_t f;
  logic bus_zero, dev_in, fn_in, idx_in;

  always_comb begin
    f         = pvw_split(addr);
    shape_bad = !pvw_shape_ok(len, f.lane);
    bus_zero  = (f.bus == 8'd0);
    root_hit  = bus_zero && (f.dev == 5'd0) && (f.fn == 3'd0);
    dev_in    = (f.dev != 5'd0) && (32'(f.dev) <= 32'(DEV_COUNT));
    fn_in     = 32'(f.fn) < 32'(FUNC_COUNT);
    idx_in    = 32'(f.idx) < 32'(REGS_PER_PAGE);
    slot_hit  = bus_zero && dev_in && fn_in && idx_in;
    word_idx  = slot_hit ? IDX_W'(pvw_word_index(f, FUNC_COUNT, REGS_PER_PAGE))
                         : '0;
  end

endmodule

// File: rtl/pvw_store.sv
module pvw_store #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  logic [31:0] words [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          words[g] <= '0;
        else if (we && (32'(idx) == 32'(g))) words[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = words[idx];

endmodule

// File: rtl/pvw_window.sv
module pvw_window #(
  parameter int DEV_COUNT     = 2,
  parameter int FUNC_COUNT    = 2,
  parameter int REGS_PER_PAGE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [28:0] req_addr,
  input  logic [2:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err
);

  localparam int DEPTH = DEV_COUNT * FUNC_COUNT * 2 * REGS_PER_PAGE;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             shape_bad, root_hit, slot_hit;
  logic [IDX_W-1:0] word_idx;
  logic [31:0]      store_rdata;

  // Named events for the checker.
  logic access_bad, store_we, read_hit;

  pvw_decode #(
    .DEV_COUNT    (DEV_COUNT),
    .FUNC_COUNT   (FUNC_COUNT),
    .REGS_PER_PAGE(REGS_PER_PAGE)
  ) u_decode (
    .addr     (req_addr),
    .len      (req_len),
    .shape_bad(shape_bad),
    .root_hit (root_hit),
    .slot_hit (slot_hit),
    .word_idx (word_idx)
  );

  assign access_bad = req_valid && shape_bad;
  assign store_we   = req_valid && req_write && !shape_bad && slot_hit && !root_hit;
  assign read_hit   = req_valid && !req_write && !shape_bad && slot_hit && !root_hit;

  pvw_store #(
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (store_we),
    .idx  (word_idx),
    .wdata(req_wdata),
    .rdata(store_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= access_bad;
      rsp_rdata <= read_hit ? store_rdata : 32'd0;
    end
  end

endmodule

// File: rtl/pvw_window_chk.sv
module pvw_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [28:0] req_addr,
  input logic [2:0]  req_len,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err,
  input logic        store_we,
  input logic        root_hit
);

  logic well_formed;
  assign well_formed = (req_addr[1:0] == 2'd0) && (req_len == 3'd4);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_write_rsp_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 32'd0));

  assert_misaligned_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'd0) |=> (rsp_err && rsp_rdata == 32'd0));

  assert_store_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |-> (req_valid && req_write && well_formed));

  assert_bad_len_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len != 3'd4) |=> (rsp_err && rsp_rdata == 32'd0));

  assert_root_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && root_hit && well_formed) |=> (!rsp_err && rsp_rdata == 32'd0));

  assert_root_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    root_hit |-> !store_we);

  assert_err_needs_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  assert_no_err_spill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && well_formed) |=> !rsp_err);

endmodule

bind pvw_window pvw_window_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_len  (req_len),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err),
  .store_we (store_we),
  .root_hit (root_hit)
);

// File: tb/pvw_window_tb.sv
`timescale 1ns/1ps
module pvw_window_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [28:0] req_addr = '0;
  logic [2:0]  req_len = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pvw_window u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_len  (req_len),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err)
  );

  function automatic logic [28:0] mk(int bus, int dev, int fn, int page, int r);
    return {8'(bus), 5'(dev), 3'(fn), 1'(page), 10'(r), 2'b00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One request, response sampled at the following falling edge.
  task automatic xfer(bit wr, logic [28:0] a, logic [2:0] l, logic [31:0] d,
                      output logic [31:0] rd, output logic er);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = l; req_wdata = d;
    @(negedge clk);
    rd = rsp_rdata; er = rsp_err;
    chk("R2 rsp_valid", 32'(rsp_valid), 32'd1);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd4(logic [28:0] a, output logic [31:0] rd, output logic er);
    xfer(1'b0, a, 3'd4, 32'd0, rd, er);
  endtask

  task automatic t_reset;
    logic [31:0] rd; logic er;
    chk("R1 rsp_valid reset", 32'(rsp_valid), 32'd0);
    chk("R1 rsp_err reset", 32'(rsp_err), 32'd0);
    rd4(mk(0, 1, 0, 0, 3), rd, er);
    chk("R1 register zero", rd, 32'd0);
    rd4(mk(0, 2, 1, 1, 7), rd, er);
    chk("R1 register zero p1", rd, 32'd0);
    @(negedge clk);
    chk("R2 idle no rsp", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_pages;
    logic [31:0] rd; logic er;
    xfer(1'b1, mk(0, 1, 0, 0, 3), 3'd4, 32'hA1A2_A3A4, rd, er);
    chk("R2 write rdata zero", rd, 32'd0);
    xfer(1'b1, mk(0, 1, 0, 1, 3), 3'd4, 32'hB1B2_B3B4, rd, er);
    rd4(mk(0, 1, 0, 0, 3), rd, er);
    chk("R3 page0 readback", rd, 32'hA1A2_A3A4);
    rd4(mk(0, 1, 0, 1, 3), rd, er);
    chk("R3 page1 readback", rd, 32'hB1B2_B3B4);
    chk("R3 no error", 32'(er), 32'd0);
  endtask

  task automatic t_independent;
    logic [31:0] rd; logic er;
    xfer(1'b1, mk(0, 2, 1, 0, 3), 3'd4, 32'hC0C0_0001, rd, er);
    rd4(mk(0, 1, 1, 0, 3), rd, er);
    chk("R4 dev1 fn1 untouched", rd, 32'd0);
    rd4(mk(0, 2, 0, 0, 3), rd, er);
    chk("R4 dev2 fn0 untouched", rd, 32'd0);
    rd4(mk(0, 1, 0, 0, 3), rd, er);
    chk("R4 dev1 fn0 kept", rd, 32'hA1A2_A3A4);
    rd4(mk(0, 2, 1, 0, 3), rd, er);
    chk("R4 dev2 fn1 readback", rd, 32'hC0C0_0001);
  endtask

  task automatic t_misaligned;
    logic [31:0] rd; logic er;
    xfer(1'b1, mk(0, 1, 0, 0, 3) | 29'd1, 3'd4, 32'hDEAD_0001, rd, er);
    chk("R5 write err", 32'(er), 32'd1);
    rd4(mk(0, 1, 0, 0, 3), rd, er);
    chk("R5 storage unchanged", rd, 32'hA1A2_A3A4);
    chk("R5 err cleared", 32'(er), 32'd0);
    rd4(mk(0, 1, 0, 0, 3) | 29'd2, rd, er);
    chk("R5 read err", 32'(er), 32'd1);
    chk("R5 read zero", rd, 32'd0);
  endtask

  task automatic t_len;
    logic [31:0] rd; logic er;
    xfer(1'b1, mk(0, 1, 0, 1, 3), 3'd2, 32'hDEAD_0002, rd, er);
    chk("R6 short write err", 32'(er), 32'd1);
    rd4(mk(0, 1, 0, 1, 3), rd, er);
    chk("R6 storage unchanged", rd, 32'hB1B2_B3B4);
    xfer(1'b0, mk(0, 1, 0, 1, 3), 3'd1, 32'd0, rd, er);
    chk("R6 byte read err", 32'(er), 32'd1);
    chk("R6 byte read zero", rd, 32'd0);
  endtask

  task automatic t_root;
    logic [31:0] rd; logic er;
    xfer(1'b1, mk(0, 0, 0, 0, 3), 3'd4, 32'h5555_AAAA, rd, er);
    chk("R7 root write no err", 32'(er), 32'd0);
    rd4(mk(0, 0, 0, 0, 3), rd, er);
    chk("R7 root reads zero", rd, 32'd0);
    rd4(mk(0, 0, 0, 1, 0), rd, er);
    chk("R7 root page1 zero", rd, 32'd0);
    rd4(mk(0, 1, 0, 0, 3), rd, er);
    chk("R7 no alias", rd, 32'hA1A2_A3A4);
  endtask

  task automatic t_absent;
    logic [31:0] rd; logic er;
    xfer(1'b1, mk(1, 1, 0, 0, 3), 3'd4, 32'h1111_0001, rd, er);
    chk("R8 bus1 no err", 32'(er), 32'd0);
    xfer(1'b1, mk(0, 3, 0, 0, 3), 3'd4, 32'h1111_0002, rd, er);
    xfer(1'b1, mk(0, 1, 2, 0, 3), 3'd4, 32'h1111_0003, rd, er);
    rd4(mk(1, 1, 0, 0, 3), rd, er);
    chk("R8 bus1 reads zero", rd, 32'd0);
    rd4(mk(0, 3, 0, 0, 3), rd, er);
    chk("R8 dev3 reads zero", rd, 32'd0);
    rd4(mk(0, 1, 2, 0, 3), rd, er);
    chk("R8 fn2 reads zero", rd, 32'd0);
    chk("R8 no err", 32'(er), 32'd0);
    rd4(mk(0, 1, 0, 0, 3), rd, er);
    chk("R8 dev1 fn0 kept", rd, 32'hA1A2_A3A4);
  endtask

  task automatic t_beyond;
    logic [31:0] rd; logic er;
    xfer(1'b1, mk(0, 1, 0, 0, 8), 3'd4, 32'h2222_0008, rd, er);
    xfer(1'b1, mk(0, 1, 0, 0, 11), 3'd4, 32'h2222_000B, rd, er);
    rd4(mk(0, 1, 0, 0, 8), rd, er);
    chk("R9 idx8 reads zero", rd, 32'd0);
    rd4(mk(0, 1, 0, 0, 0), rd, er);
    chk("R9 idx0 not aliased", rd, 32'd0);
    rd4(mk(0, 1, 0, 0, 3), rd, er);
    chk("R9 idx3 not aliased", rd, 32'hA1A2_A3A4);
  endtask

  task automatic t_back2back;
    // Bad read, then good read, then good write, with no idle between.
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk(0, 2, 1, 0, 3) | 29'd3; req_len = 3'd4;
    @(negedge clk);
    chk("R10 first err", 32'(rsp_err), 32'd1);
    chk("R10 first zero", rsp_rdata, 32'd0);
    req_addr = mk(0, 2, 1, 0, 3);
    @(negedge clk);
    chk("R10 second no err", 32'(rsp_err), 32'd0);
    chk("R10 second data", rsp_rdata, 32'hC0C0_0001);
    req_write = 1'b1; req_addr = mk(0, 2, 0, 1, 7); req_wdata = 32'h7777_0007;
    @(negedge clk);
    chk("R10 third valid", 32'(rsp_valid), 32'd1);
    req_write = 1'b0;
    @(negedge clk);
    chk("R10 readback pipelined", rsp_rdata, 32'h7777_0007);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R2 valid drops", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pages();
    t_independent();
    t_misaligned();
    t_len();
    t_root();
    t_absent();
    t_beyond();
    t_back2back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule